// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Rights

The block caches recently used page mappings. It compares a virtual page number against every stored entry in one cycle. On a match it returns the physical frame number, joined with the untranslated page offset to form the physical address. Each entry has separate read and write rights for user and supervisor mode. A match that lacks the right for the requested access is reported as a protection fault and not as a hit.

When no valid entry matches, the block raises a stall. An external page-table walker then supplies the missing mapping on the fill port. The block chooses a slot for the new mapping from the entries' valid and reference bits. Each entry also keeps a dirty bit. The first write that hits a clean entry raises a request so that the page-table copy can be marked dirty. A flush input empties the whole buffer when the running process changes.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup is compared against all 32 entries in the same cycle, and only valid entries can match. On a permitted match, `hit_o` is high in that cycle and `pfn_o` carries the stored 21-bit frame number.
- R2: `paddr_o` is 34 bits: the frame number in bits 33:13 and `lookup_offset_i` unchanged in bits 12:0.
- R3: `miss_stall_o` is high while `lookup_valid_i` is high and no valid entry matches. A fill for that page number installs it, and the held lookup hits from the next cycle.
- R4: In each 2-bit rights field, bit 0 grants user access and bit 1 grants supervisor access (00 none, 01 user, 10 supervisor, 11 both). A read is checked against the read field and a write against the write field, using the mode given by `supervisor_i`. A match without the needed right raises `prot_fault_o`, and `hit_o` stays low.
- R5: A write hit on an entry whose dirty bit is clear raises `dirty_req_o` in that cycle. The dirty bit is set at the clock edge, so later write hits to that entry do not raise the request. A fill presets the dirty bit from `fill_dirty_i`.
- R6: A fill whose page number matches a valid entry overwrites that entry, so no duplicate entry is created.
- R7: Otherwise, a fill goes to the lowest-numbered invalid entry.
- R8: When all entries are valid, a fill replaces the lowest-numbered entry whose reference bit is clear. A hit sets the entry's reference bit, and a fill sets the reference bit of the entry it writes.
- R9: When all entries are valid and all reference bits are set, a fill clears every reference bit and replaces entry 0.
- R10: `flush_i` invalidates every entry at the next clock edge. A fill in the same cycle as a flush is discarded.
- R11: After reset every entry is invalid, so every lookup misses. While `lookup_valid_i` is low, `hit_o`, `prot_fault_o`, `miss_stall_o` and `dirty_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | A lookup is presented this cycle |
| lookup_write_i | input | 1 | The access is a write (0: read) |
| supervisor_i | input | 1 | The access is made in supervisor mode |
| lookup_vpn_i | input | 30 | Virtual page number to translate |
| lookup_offset_i | input | 13 | Page offset, passed through untranslated |
| flush_i | input | 1 | Invalidate all entries |
| fill_valid_i | input | 1 | Install the mapping on the fill port |
| fill_vpn_i | input | 30 | Virtual page number of the fill |
| fill_pfn_i | input | 21 | Frame number of the fill |
| fill_rd_perm_i | input | 2 | Read rights of the fill |
| fill_wr_perm_i | input | 2 | Write rights of the fill |
| fill_dirty_i | input | 1 | Initial dirty bit of the fill |
| hit_o | output | 1 | Permitted match |
| prot_fault_o | output | 1 | Match without the needed right |
| miss_stall_o | output | 1 | No valid match; the requester stalls |
| dirty_req_o | output | 1 | First write hit to a clean entry |
| pfn_o | output | 21 | Frame number of the matching entry |
| paddr_o | output | 34 | Translated physical address |

## Verification
Two pairs of events can fall in the same cycle. In the first, a flush and a fill arrive together. The bench drives both in one cycle and then looks up the filled page and a page that was valid before. Both lookups must miss. In the second, a lookup waits on a miss while the walker's fill arrives. The bench keeps the missing lookup asserted through the fill cycle. The lookup must report a stall in that cycle and a hit with the filled frame in the next.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ENTRIES_DEF = 32;
  localparam int VPN_W_DEF   = 30;
  localparam int PFN_W_DEF   = 21;
  localparam int OFF_W_DEF   = 13;
  localparam int PERM_W      = 2;

  typedef enum logic [PERM_W-1:0] {
    PERM_NONE  = 2'b00,
    PERM_USER  = 2'b01,
    PERM_SUPER = 2'b10,
    PERM_BOTH  = 2'b11
  } perm_e;

  function automatic logic perm_grants(input logic [PERM_W-1:0] perm, input logic sup);
    return sup ? perm[1] : perm[0];
  endfunction
endpackage

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter  int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 32,
  parameter int TAG_W = 30
) (
  input  logic [N-1:0]     valid_i,
  input  logic [TAG_W-1:0] tag_i [N],
  input  logic [TAG_W-1:0] key_a_i,
  input  logic [TAG_W-1:0] key_b_i,
  output logic [N-1:0]     match_a_o,
  output logic [N-1:0]     match_b_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_a_o[g] = valid_i[g] && (tag_i[g] == key_a_i);
    assign match_b_o[g] = valid_i[g] && (tag_i[g] == key_b_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter  int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  fill_match_i,
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  ref_i,
  output logic [IW-1:0] victim_o,
  output logic          clear_ref_o
);
  logic          dup_any, free_any, cold_any;
  logic [IW-1:0] dup_idx, free_idx, cold_idx;

  tlb_first_one #(.N(N)) i_dup  (.vec_i(fill_match_i), .any_o(dup_any),  .idx_o(dup_idx));
  tlb_first_one #(.N(N)) i_free (.vec_i(~valid_i),     .any_o(free_any), .idx_o(free_idx));
  tlb_first_one #(.N(N)) i_cold (.vec_i(~ref_i),       .any_o(cold_any), .idx_o(cold_idx));

  always_comb begin
    clear_ref_o = 1'b0;
    if (dup_any)       victim_o = dup_idx;
    else if (free_any) victim_o = free_idx;
    else if (cold_any) victim_o = cold_idx;
    else begin
      victim_o    = '0;
      clear_ref_o = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter  int N      = 32,
  parameter  int VPN_W  = 30,
  parameter  int PFN_W  = 21,
  parameter  int PERM_W = 2,
  localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fill_en_i,
  input  logic [IW-1:0]     fill_idx_i,
  input  logic              clear_ref_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PERM_W-1:0] fill_rd_i,
  input  logic [PERM_W-1:0] fill_wr_i,
  input  logic              fill_dirty_i,
  input  logic              touch_en_i,
  input  logic [IW-1:0]     touch_idx_i,
  input  logic              touch_wr_i,
  output logic [N-1:0]      valid_o,
  output logic [N-1:0]      ref_o,
  output logic [N-1:0]      dirty_o,
  output logic [VPN_W-1:0]  tag_o [N],
  output logic [PFN_W-1:0]  pfn_o [N],
  output logic [PERM_W-1:0] rd_o [N],
  output logic [PERM_W-1:0] wr_o [N]
);
  logic [N-1:0] valid_q, ref_q, dirty_q;
  logic [N-1:0] valid_d, ref_d, dirty_d;

  always_comb begin
    valid_d = valid_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    if (fill_en_i && clear_ref_i) ref_d = '0;
    if (touch_en_i) begin
      ref_d[touch_idx_i] = 1'b1;
      if (touch_wr_i) dirty_d[touch_idx_i] = 1'b1;
    end
    if (fill_en_i) begin
      valid_d[fill_idx_i] = 1'b1;
      ref_d[fill_idx_i]   = 1'b1;
      dirty_d[fill_idx_i] = fill_dirty_i;
    end
    if (flush_i) begin
      valid_d = '0;
      ref_d   = '0;
      dirty_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  // payload needs no reset: guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (fill_en_i && !flush_i) begin
      tag_o[fill_idx_i] <= fill_vpn_i;
      pfn_o[fill_idx_i] <= fill_pfn_i;
      rd_o[fill_idx_i]  <= fill_rd_i;
      wr_o[fill_idx_i]  <= fill_wr_i;
    end
  end

  assign valid_o = valid_q;
  assign ref_o   = ref_q;
  assign dirty_o = dirty_q;
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter  int ENTRIES = ENTRIES_DEF,
  parameter  int VPN_W   = VPN_W_DEF,
  parameter  int PFN_W   = PFN_W_DEF,
  parameter  int OFF_W   = OFF_W_DEF,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W    = PFN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic              lookup_write_i,
  input  logic              supervisor_i,
  input  logic [VPN_W-1:0]  lookup_vpn_i,
  input  logic [OFF_W-1:0]  lookup_offset_i,
  input  logic              flush_i,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PERM_W-1:0] fill_rd_perm_i,
  input  logic [PERM_W-1:0] fill_wr_perm_i,
  input  logic              fill_dirty_i,
  output logic              hit_o,
  output logic              prot_fault_o,
  output logic              miss_stall_o,
  output logic              dirty_req_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [PA_W-1:0]   paddr_o
);
  logic [ENTRIES-1:0]  valid_q, ref_q, dirty_q;
  logic [VPN_W-1:0]    tag_q [ENTRIES];
  logic [PFN_W-1:0]    pfn_q [ENTRIES];
  logic [PERM_W-1:0]   rd_q  [ENTRIES];
  logic [PERM_W-1:0]   wr_q  [ENTRIES];

  logic [ENTRIES-1:0]  look_match, fill_match;
  logic                look_any;
  logic [IW-1:0]       look_idx, victim_idx;
  logic                clear_ref;
  logic [PERM_W-1:0]   need_perm;
  logic                allowed;

  tlb_cam #(.N(ENTRIES), .TAG_W(VPN_W)) i_cam (
    .valid_i   (valid_q),
    .tag_i     (tag_q),
    .key_a_i   (lookup_vpn_i),
    .key_b_i   (fill_vpn_i),
    .match_a_o (look_match),
    .match_b_o (fill_match)
  );

  tlb_first_one #(.N(ENTRIES)) i_sel (
    .vec_i (look_match),
    .any_o (look_any),
    .idx_o (look_idx)
  );

  tlb_victim #(.N(ENTRIES)) i_victim (
    .fill_match_i (fill_match),
    .valid_i      (valid_q),
    .ref_i        (ref_q),
    .victim_o     (victim_idx),
    .clear_ref_o  (clear_ref)
  );

  tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PERM_W(PERM_W)) i_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .fill_en_i    (fill_valid_i),
    .fill_idx_i   (victim_idx),
    .clear_ref_i  (clear_ref),
    .fill_vpn_i   (fill_vpn_i),
    .fill_pfn_i   (fill_pfn_i),
    .fill_rd_i    (fill_rd_perm_i),
    .fill_wr_i    (fill_wr_perm_i),
    .fill_dirty_i (fill_dirty_i),
    .touch_en_i   (hit_o),
    .touch_idx_i  (look_idx),
    .touch_wr_i   (lookup_write_i),
    .valid_o      (valid_q),
    .ref_o        (ref_q),
    .dirty_o      (dirty_q),
    .tag_o        (tag_q),
    .pfn_o        (pfn_q),
    .rd_o         (rd_q),
    .wr_o         (wr_q)
  );

  assign need_perm    = lookup_write_i ? wr_q[look_idx] : rd_q[look_idx];
  assign allowed      = perm_grants(need_perm, supervisor_i);
  assign hit_o        = lookup_valid_i && look_any && allowed;
  assign prot_fault_o = lookup_valid_i && look_any && !allowed;
  assign miss_stall_o = lookup_valid_i && !look_any;
  assign dirty_req_o  = hit_o && lookup_write_i && !dirty_q[look_idx];
  assign pfn_o        = pfn_q[look_idx];
  assign paddr_o      = {pfn_q[look_idx], lookup_offset_i};
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int VPN_W = 30,
  parameter int PFN_W = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_valid_i,
  input logic             lookup_write_i,
  input logic [VPN_W-1:0] lookup_vpn_i,
  input logic             flush_i,
  input logic             fill_valid_i,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic [PFN_W-1:0] fill_pfn_i,
  input logic             hit_o,
  input logic             prot_fault_o,
  input logic             miss_stall_o,
  input logic             dirty_req_o,
  input logic [PFN_W-1:0] pfn_o
);
  AST_FILL_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && $past(fill_valid_i && !flush_i) && lookup_vpn_i == $past(fill_vpn_i))
      |-> ((hit_o || prot_fault_o) && pfn_o == $past(fill_pfn_i))); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !(hit_o || prot_fault_o)); // R10

  AST_DIRTY_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dirty_req_o && !flush_i && !fill_valid_i)
      |=> !(hit_o && lookup_write_i && lookup_vpn_i == $past(lookup_vpn_i) && dirty_req_o)); // R5

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, prot_fault_o, miss_stall_o})); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> !(hit_o || prot_fault_o || miss_stall_o || dirty_req_o)); // R11
endmodule

bind tlb_assoc tlb_assoc_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .lookup_write_i (lookup_write_i),
  .lookup_vpn_i   (lookup_vpn_i),
  .flush_i        (flush_i),
  .fill_valid_i   (fill_valid_i),
  .fill_vpn_i     (fill_vpn_i),
  .fill_pfn_i     (fill_pfn_i),
  .hit_o          (hit_o),
  .prot_fault_o   (prot_fault_o),
  .miss_stall_o   (miss_stall_o),
  .dirty_req_o    (dirty_req_o),
  .pfn_o          (pfn_o)
);

// File: tb/test_tlb_assoc.sv
module test_tlb_assoc;
  localparam int N = 32;
  localparam int NV = 14;
  // {vpn[30], write, sup, offset[13], hit, prot, miss, dreq, pfn[21]}
  localparam logic [69:0] VEC [NV] = '{
    {30'h10,       1'b0, 1'b0, 13'h020,  1'b1, 1'b0, 1'b0, 1'b0, 21'h22},
    {30'h10,       1'b0, 1'b1, 13'h1FFF, 1'b1, 1'b0, 1'b0, 1'b0, 21'h22},
    {30'h10,       1'b1, 1'b1, 13'h000,  1'b0, 1'b1, 1'b0, 1'b0, 21'h22},
    {30'h10,       1'b1, 1'b0, 13'h005,  1'b1, 1'b0, 1'b0, 1'b1, 21'h22},
    {30'h10,       1'b1, 1'b0, 13'h006,  1'b1, 1'b0, 1'b0, 1'b0, 21'h22},
    {30'h3FFFFFFF, 1'b0, 1'b0, 13'h001,  1'b0, 1'b1, 1'b0, 1'b0, 21'h1FFFFF},
    {30'h3FFFFFFF, 1'b1, 1'b1, 13'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 21'h1FFFFF},
    {30'h45,       1'b0, 1'b0, 13'h0AB,  1'b1, 1'b0, 1'b0, 1'b0, 21'h45},
    {30'h45,       1'b0, 1'b1, 13'h0AB,  1'b0, 1'b1, 1'b0, 1'b0, 21'h45},
    {30'h45,       1'b1, 1'b0, 13'h0AB,  1'b0, 1'b1, 1'b0, 1'b0, 21'h45},
    {30'h2,        1'b0, 1'b1, 13'h010,  1'b0, 1'b1, 1'b0, 1'b0, 21'h7},
    {30'h2,        1'b1, 1'b1, 13'h011,  1'b1, 1'b0, 1'b0, 1'b1, 21'h7},
    {30'h99,       1'b0, 1'b0, 13'h000,  1'b0, 1'b0, 1'b1, 1'b0, 21'h0},
    {30'h11,       1'b1, 1'b1, 13'h000,  1'b0, 1'b0, 1'b1, 1'b0, 21'h0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0, lookup_write_i = 1'b0, supervisor_i = 1'b0;
  logic [29:0] lookup_vpn_i = '0;
  logic [12:0] lookup_offset_i = '0;
  logic        flush_i = 1'b0, fill_valid_i = 1'b0, fill_dirty_i = 1'b0;
  logic [29:0] fill_vpn_i = '0;
  logic [20:0] fill_pfn_i = '0;
  logic [1:0]  fill_rd_perm_i = '0, fill_wr_perm_i = '0;
  logic        hit_o, prot_fault_o, miss_stall_o, dirty_req_o;
  logic [20:0] pfn_o;
  logic [33:0] paddr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb_assoc i_tlb_assoc (
    .clk_i(clk), .rst_ni(rst_ni),
    .lookup_valid_i(lookup_valid_i), .lookup_write_i(lookup_write_i),
    .supervisor_i(supervisor_i), .lookup_vpn_i(lookup_vpn_i),
    .lookup_offset_i(lookup_offset_i), .flush_i(flush_i),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
    .fill_rd_perm_i(fill_rd_perm_i), .fill_wr_perm_i(fill_wr_perm_i),
    .fill_dirty_i(fill_dirty_i), .hit_o(hit_o), .prot_fault_o(prot_fault_o),
    .miss_stall_o(miss_stall_o), .dirty_req_o(dirty_req_o), .pfn_o(pfn_o),
    .paddr_o(paddr_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [29:0] vpn, input logic [20:0] pfn,
                         input logic [1:0] rd, input logic [1:0] wr, input logic dty,
                         input logic with_flush);
    @(negedge clk);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_pfn_i = pfn;
    fill_rd_perm_i = rd; fill_wr_perm_i = wr; fill_dirty_i = dty;
    flush_i = with_flush;
    @(posedge clk);
    #1 fill_valid_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    @(posedge clk);
    #1 flush_i = 1'b0;
  endtask

  // present a lookup for one cycle; outputs sampled mid-cycle
  task automatic look(input logic [29:0] vpn, input logic wr, input logic sup,
                      input logic [12:0] off);
    @(negedge clk);
    lookup_valid_i = 1'b1; lookup_vpn_i = vpn; lookup_write_i = wr;
    supervisor_i = sup; lookup_offset_i = off;
    #1;
  endtask

  task automatic look_end();
    @(posedge clk);
    #1 lookup_valid_i = 1'b0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R11: quiet when idle, empty after reset
    #1;
    chk("R11 idle outputs", {hit_o, prot_fault_o, miss_stall_o, dirty_req_o}, 4'b0000);
    look(30'h0, 1'b0, 1'b1, 13'h0);
    chk("R11 lookup after reset misses", {hit_o, prot_fault_o, miss_stall_o}, 3'b001);
    look_end();

    // R7: fills go to free slots
    do_fill(30'h10,       21'h22,     2'b11, 2'b01, 1'b0, 1'b0);
    do_fill(30'h3FFFFFFF, 21'h1FFFFF, 2'b10, 2'b10, 1'b1, 1'b0);
    do_fill(30'h45,       21'h45,     2'b01, 2'b00, 1'b0, 1'b0);
    do_fill(30'h2,        21'h7,      2'b00, 2'b11, 1'b0, 1'b0);

    // vector table: R1 R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      logic [69:0] v;
      v = VEC[k];
      look(v[69:40], v[39], v[38], v[37:25]);
      chk("R1 hit", hit_o, v[24]);
      chk("R4 prot_fault", prot_fault_o, v[23]);
      chk("R3 miss_stall", miss_stall_o, v[22]);
      chk("R5 dirty_req", dirty_req_o, v[21]);
      if (v[24]) begin
        chk("R1 pfn", pfn_o, v[20:0]);
        chk("R2 paddr", paddr_o, {v[20:0], v[37:25]});
      end
      look_end();
    end

    // R3: held miss resolved by a fill in the same cycle
    look(30'h123, 1'b0, 1'b0, 13'h44);
    chk("R3 stall before fill", miss_stall_o, 1'b1);
    fill_valid_i = 1'b1; fill_vpn_i = 30'h123; fill_pfn_i = 21'h0ABCD;
    fill_rd_perm_i = 2'b11; fill_wr_perm_i = 2'b11; fill_dirty_i = 1'b0;
    @(posedge clk);
    #1 fill_valid_i = 1'b0;
    @(negedge clk); #1;
    chk("R3 hit after fill", {hit_o, miss_stall_o}, 2'b10);
    chk("R3 filled paddr", paddr_o, {21'h0ABCD, 13'h44});
    look_end();

    // R10: flush together with a fill
    do_fill(30'h77, 21'h77, 2'b11, 2'b11, 1'b0, 1'b1);
    look(30'h77, 1'b0, 1'b0, 13'h0);
    chk("R10 fill beside flush dropped", miss_stall_o, 1'b1);
    look_end();
    look(30'h10, 1'b0, 1'b0, 13'h0);
    chk("R10 old entry flushed", {hit_o, prot_fault_o, miss_stall_o}, 3'b001);
    look_end();

    // R6: repeated page number overwrites, no duplicate
    do_fill(30'h200, 21'h1, 2'b11, 2'b11, 1'b0, 1'b0);
    do_fill(30'h200, 21'h2, 2'b11, 2'b11, 1'b0, 1'b0);
    look(30'h200, 1'b0, 1'b0, 13'h0);
    chk("R6 refill overwrites", pfn_o, 21'h2);
    look_end();

    // R8/R9: fill every slot, all references set
    do_flush();
    for (int i = 0; i < N; i++) do_fill(30'(100 + i), 21'(i + 16), 2'b11, 2'b11, 1'b0, 1'b0);
    look(30'd131, 1'b0, 1'b0, 13'h0);
    chk("R7 last free slot used", {hit_o, pfn_o}, {1'b1, 21'd47});
    look_end();
    do_fill(30'd500, 21'd500, 2'b11, 2'b11, 1'b0, 1'b0);
    look(30'd100, 1'b0, 1'b0, 13'h0);
    chk("R9 entry 0 replaced", miss_stall_o, 1'b1);
    look_end();
    look(30'd500, 1'b0, 1'b0, 13'h0);
    chk("R9 new entry present", {hit_o, pfn_o}, {1'b1, 21'd500});
    look_end();
    look(30'd101, 1'b0, 1'b0, 13'h0);   // sets reference of entry 1
    chk("R8 entry 1 still present", hit_o, 1'b1);
    look_end();
    do_fill(30'd501, 21'd501, 2'b11, 2'b11, 1'b0, 1'b0);
    look(30'd102, 1'b0, 1'b0, 13'h0);
    chk("R8 first cold entry replaced", miss_stall_o, 1'b1);
    look_end();
    look(30'd101, 1'b0, 1'b0, 13'h0);
    chk("R8 referenced entry kept", hit_o, 1'b1);
    look_end();
    look(30'd103, 1'b0, 1'b0, 13'h0);
    chk("R8 later cold entry kept", hit_o, 1'b1);
    look_end();
    look(30'd501, 1'b0, 1'b0, 13'h0);
    chk("R8 new entry present", {hit_o, pfn_o}, {1'b1, 21'd501});
    look_end();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule